// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets a clocked system read and write a 128K x 8 asynchronous static RAM. A client hands over one request at a time on a valid/ready port: a read/write flag, a 17-bit address and, for writes, a data byte. The controller then runs the memory pins through a timed sequence. It drives the address, an active-low and an active-high chip select, write enable, output enable, and the outgoing data through a tri-state enable. Read data comes back on a registered output together with a one-cycle valid pulse.

Each phase length is a whole number of clock cycles. It is derived from the memory's nanosecond minimums and the clock period, which is a parameter. Before the controller drives the data bus it waits out the memory's output release time. A retention input parks the memory in its low-power standby. When that input is released, the controller holds off all accesses for the memory's recovery time, which is counted in cycles.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `req_ready` is 1, `rd_valid` is 0, `mem_sel_n`=1, `mem_sel`=0, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R2: A write pulse lasts exactly WP cycles, where WP is the largest phase count of the 45 ns pulse, 50 ns address-to-end, 50 ns select-to-end, 25 ns data setup and 55 ns cycle minimums. During the pulse `mem_sel_n`=0, `mem_sel`=1, `mem_we_n`=0, `mem_oe_n`=1, `mem_dq_oe`=1, and the request's address and data are on the pins. In the cycle after the pulse the data is still driven, while write enable and both selects are inactive.
- R3: A read accepted at edge k holds `mem_sel_n`=0, `mem_sel`=1, `mem_oe_n`=0, `mem_we_n`=1 and `mem_dq_oe`=0 for RD cycles. RD is the largest phase count of the 55 ns cycle, 55 ns address access, 55 ns select access and 30 ns output-enable access. At edge k+RD the bus is sampled, and `rd_valid` is 1 for exactly that one following cycle, with `rd_data` holding the sampled byte.
- R4: A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 from that edge until the access completes: RD cycles for a read, and the pulse plus one hold cycle for a write. A request offered while `req_ready` is 0 has no effect on the memory.
- R5: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After a read ending at edge e, the write pulse starts at edge max(accept, e+TA+1), where TA is the phase count of the 20 ns output release time.
- R6: Outside a read or write sequence, both selects are inactive, `mem_we_n`=1, `mem_oe_n`=1 and `mem_dq_oe`=0.
- R7: While idle with no request, a high `retain_req` puts the block into retention. In retention, `mem_sel`=0, `mem_sel_n`=1 and `req_ready`=0 until `retain_req` falls.
- R8: When `retain_req` falls at edge r, `req_ready` stays 0 until edge r+REC. REC is the phase count of the recovery time, 5 ms by default.
- R9: A phase count is max(1, ceil(t_ns*1000 / CLK_PS)). At the memory pins this gives a write pulse of at least 45 ns, address stable at least 50 ns before write end, data stable at least 25 ns before write end, and read data sampled no sooner than 55 ns after the read starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse, read data valid |
| rd_data | output | DATA_W | Registered read data |
| retain_req | input | 1 | Hold memory in retention standby |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_sel_n | output | 1 | Active-low chip select |
| mem_sel | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq_out | output | DATA_W | Outgoing data bus value |
| mem_dq_oe | output | 1 | Tri-state enable for outgoing data |
| mem_dq_in | input | DATA_W | Incoming data bus value |

## Verification
For a read accepted at edge k, the read strobes cover the cycles after edges k to k+RD-1, and `rd_valid` with its data appears after edge k+RD. For a write, the pulse starts at edge s = max(k, last read end + TA + 1), covers s to s+WP-1, and `req_ready` returns after edge s+WP+1. After retention is released at edge r, `req_ready` returns after edge r+REC. The bench model recomputes these edge numbers from its own phase counts and compares every output at each falling edge. A behavioural memory beside it measures pulse widths, setup times and bus overlap in nanoseconds. A read that is sampled too early gets back a corrupted byte.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_WWAIT  = 3'd1,
    ST_WPULSE = 3'd2,
    ST_WHOLD  = 3'd3,
    ST_RACC   = 3'd4,
    ST_RETAIN = 3'd5,
    ST_RECOV  = 3'd6
  } ctl_state_t;

  // Clock cycles covering a nanosecond minimum, never less than one.
  function automatic int phase_cycles(int t_ns, int clk_ps);
    longint t_ps;
    longint c;
    t_ps = longint'(t_ns) * 64'sd1000;
    c    = (t_ps + longint'(clk_ps) - 64'sd1) / longint'(clk_ps);
    if (c < 64'sd1) c = 64'sd1;
    return int'(c);
  endfunction

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int max3(int a, int b, int c);
    return max2(max2(a, b), c);
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [CNT_W-1:0] limit,
  output logic             last
);
  logic [CNT_W-1:0] cnt;

  assign last = (cnt == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (restart) cnt <= '0;
    else if (!last && cnt != '1) cnt <= cnt + 1'b1;
  end

  // R9
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && $past(last) && !$past(restart)) |-> $stable(cnt));
endmodule

// File: rtl/sram_bus_turn.sv
`timescale 1ns/1ps
module sram_bus_turn #(
  parameter int TA_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mem_reading,
  output logic ta_done
);
  localparam int CW = $clog2(TA_CYC + 1) + 1;
  logic [CW-1:0] cnt;

  assign ta_done = (cnt >= CW'(TA_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= CW'(TA_CYC);
    else if (mem_reading) cnt <= '0;
    else if (!ta_done)    cnt <= cnt + 1'b1;
  end

  // R5
  turn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_reading |=> !ta_done);
endmodule

// File: rtl/sram_pin_stage.sv
`timescale 1ns/1ps
module sram_pin_stage
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctl_state_t        st,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              capture,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              selected;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= dq_in;
    end
  end

  assign selected   = (st == ST_WPULSE) || (st == ST_RACC);
  assign mem_addr   = addr_q;
  assign mem_sel_n  = !selected;
  assign mem_sel    = selected;
  assign mem_we_n   = (st != ST_WPULSE);
  assign mem_oe_n   = (st != ST_RACC);
  assign mem_dq_out = data_q;
  assign mem_dq_oe  = (st == ST_WPULSE) || (st == ST_WHOLD);

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !load) |=> $stable(mem_addr));

  // R3
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_PS    = 8000,
  parameter int ADDR_W    = 17,
  parameter int DATA_W    = 8,
  parameter int T_WC_NS   = 55,
  parameter int T_WP_NS   = 45,
  parameter int T_AW_NS   = 50,
  parameter int T_CW_NS   = 50,
  parameter int T_DW_NS   = 25,
  parameter int T_RC_NS   = 55,
  parameter int T_AA_NS   = 55,
  parameter int T_ACS_NS  = 55,
  parameter int T_OE_NS   = 30,
  parameter int T_HZ_NS   = 20,
  parameter int T_REC_NS  = 5000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              retain_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_sel,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int WP_CYC = max3(
      max3(phase_cycles(T_WP_NS, CLK_PS), phase_cycles(T_AW_NS, CLK_PS),
           phase_cycles(T_CW_NS, CLK_PS)),
      phase_cycles(T_DW_NS, CLK_PS), phase_cycles(T_WC_NS, CLK_PS));
  localparam int RD_CYC = max2(
      max3(phase_cycles(T_RC_NS, CLK_PS), phase_cycles(T_AA_NS, CLK_PS),
           phase_cycles(T_ACS_NS, CLK_PS)),
      phase_cycles(T_OE_NS, CLK_PS));
  localparam int TA_CYC  = phase_cycles(T_HZ_NS, CLK_PS);
  localparam int REC_CYC = phase_cycles(T_REC_NS, CLK_PS);
  localparam int CNT_W   = $clog2(max3(WP_CYC, RD_CYC, REC_CYC) + 1) + 1;

  ctl_state_t       st, st_nxt;
  logic             accept;
  logic             ta_done;
  logic             phase_last;
  logic             capture;
  logic             mem_reading;
  logic [CNT_W-1:0] phase_limit;

  assign req_ready   = (st == ST_IDLE);
  assign accept      = req_valid && req_ready;
  assign mem_reading = (st == ST_RACC);

  always_comb begin
    st_nxt  = st;
    capture = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (accept) begin
          if (!req_write)   st_nxt = ST_RACC;
          else if (ta_done) st_nxt = ST_WPULSE;
          else              st_nxt = ST_WWAIT;
        end else if (retain_req) begin
          st_nxt = ST_RETAIN;
        end
      end
      ST_WWAIT:  if (ta_done) st_nxt = ST_WPULSE;
      ST_WPULSE: if (phase_last) st_nxt = ST_WHOLD;
      ST_WHOLD:  st_nxt = ST_IDLE;
      ST_RACC: begin
        if (phase_last) begin
          st_nxt  = ST_IDLE;
          capture = 1'b1;
        end
      end
      ST_RETAIN: if (!retain_req) st_nxt = ST_RECOV;
      ST_RECOV:  if (phase_last) st_nxt = ST_IDLE;
      default:   st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  always_comb begin
    case (st)
      ST_WPULSE: phase_limit = CNT_W'(WP_CYC);
      ST_RACC:   phase_limit = CNT_W'(RD_CYC);
      ST_RECOV:  phase_limit = CNT_W'(REC_CYC);
      default:   phase_limit = '1;
    endcase
  end

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (st != st_nxt),
    .limit   (phase_limit),
    .last    (phase_last)
  );

  sram_bus_turn #(.TA_CYC(TA_CYC)) u_turn (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_reading (mem_reading),
    .ta_done     (ta_done)
  );

  sram_pin_stage #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .st         (st),
    .load       (accept),
    .addr_i     (req_addr),
    .data_i     (req_wdata),
    .capture    (capture),
    .dq_in      (mem_dq_in),
    .mem_addr   (mem_addr),
    .mem_sel_n  (mem_sel_n),
    .mem_sel    (mem_sel),
    .mem_we_n   (mem_we_n),
    .mem_oe_n   (mem_oe_n),
    .mem_dq_out (mem_dq_out),
    .mem_dq_oe  (mem_dq_oe),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data)
  );

  // R5
  no_contend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  // R5
  turn_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> ta_done);

  // R2
  write_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_sel_n && mem_sel && mem_dq_oe));

  // R4
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  // R7
  retain_desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RETAIN) |-> (!mem_sel && mem_sel_n && !req_ready));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe && !mem_sel));
endmodule

// File: tb/sim_sram_ctrl.sv
`timescale 1ns/1ps
module sim_sram_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        retain_req = 1'b0;
  logic        req_ready, rd_valid;
  logic [7:0]  rd_data;
  logic [16:0] mem_addr;
  logic        mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out;
  logic [7:0]  mem_q = 8'h00;

  sram_ctrl #(.T_REC_NS(400)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .retain_req(retain_req),
    .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_sel(mem_sel),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_dq_out(mem_dq_out),
    .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_q));

  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // own cycle counts for an 8 ns clock
  function automatic longint cyc(int ns);
    longint c = 0;
    while (c * 8 < ns) c++;
    return (c == 0) ? 1 : c;
  endfunction
  function automatic longint lmax(longint a, longint b);
    return (a > b) ? a : b;
  endfunction

  longint WP, RD, TA, REC;
  initial begin
    WP  = lmax(lmax(cyc(45), cyc(50)), lmax(cyc(25), cyc(55)));
    RD  = lmax(cyc(55), cyc(30));
    TA  = cyc(20);
    REC = cyc(400);
  end

  // ---------------- behavioural memory with timing checks ----------------
  logic [7:0] cells [int];
  realtime ws, a_chg, d_chg, rs, last_rd;
  bit wr_prev = 0, rd_prev = 0, cont_seen = 0;
  logic [16:0] a_prev = '0;
  logic [8:0]  d_prev = '0;
  initial begin
    last_rd = -1000.0; ws = 0; a_chg = 0; d_chg = 0; rs = 0;
    #0.5;
    forever begin
      bit sel_on, wr_on, rd_on;
      realtime now;
      now    = $realtime;
      sel_on = !mem_sel_n && mem_sel;
      wr_on  = sel_on && !mem_we_n;
      rd_on  = sel_on && mem_we_n && !mem_oe_n;
      if (mem_addr != a_prev) begin a_chg = now; a_prev = mem_addr; if (rd_on) rs = now; end
      if ({mem_dq_oe, mem_dq_out} != d_prev) begin d_chg = now; d_prev = {mem_dq_oe, mem_dq_out}; end
      if (wr_on && !wr_prev) begin ws = now; cont_seen = 0; end
      if (rd_on && !rd_prev) rs = now;
      if (rd_on) last_rd = now;
      if (mem_dq_oe && (rd_on || now - last_rd < 20.0)) cont_seen = 1;
      if (!wr_on && wr_prev) begin
        // R9 timing at the pins, R5 no overlap of drivers
        check(now - ws >= 45.0, "R9", "write pulse ns", longint'(now - ws), 45);
        check(now - a_chg >= 50.0, "R9", "addr to write end ns", longint'(now - a_chg), 50);
        check(now - d_chg >= 25.0, "R9", "data setup ns", longint'(now - d_chg), 25);
        check(mem_dq_oe, "R2", "data driven at write end", mem_dq_oe, 1);
        check(!cont_seen, "R5", "bus contention", cont_seen, 0);
        cells[int'(mem_addr)] = mem_dq_out;
      end
      if (rd_on) begin
        logic [7:0] v;
        v = cells.exists(int'(mem_addr)) ? cells[int'(mem_addr)] : 8'h00;
        mem_q = (now - rs >= 55.0) ? v : ~v;
      end else mem_q = 8'h00;
      wr_prev = wr_on;
      rd_prev = rd_on;
      #1;
    end
  end

  // ---------------- cycle reference model ----------------
  logic [7:0] ref_mem [int];
  longint n = 0, busy_until = 0, last_rd_end = -100;
  longint w_lo = -10, w_hi = -20, r_lo = -10, r_hi = -20, rv_edge = -10, rec_end = -10;
  bit ret_m = 0, acc_flag = 0;
  logic [16:0] w_addr = '0, r_addr = '0;
  logic [7:0]  w_data = '0, rv_exp = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      bit rp;
      rp = (n >= busy_until) && !ret_m;
      n++;
      acc_flag = 0;
      if (rp && req_valid) begin
        acc_flag = 1;
        if (req_write) begin
          longint s;
          s = lmax(n, last_rd_end + TA + 1);
          w_lo = s; w_hi = s + WP - 1;
          w_addr = req_addr; w_data = req_wdata;
          ref_mem[int'(req_addr)] = req_wdata;
          busy_until = s + WP + 1;
        end else begin
          r_lo = n; r_hi = n + RD - 1; r_addr = req_addr;
          rv_edge = n + RD; last_rd_end = n + RD; busy_until = n + RD;
          rv_exp = ref_mem.exists(int'(req_addr)) ? ref_mem[int'(req_addr)] : 8'h00;
        end
      end else if (rp && retain_req) begin
        ret_m = 1;
      end else if (ret_m && !retain_req) begin
        ret_m = 0;
        busy_until = n + REC;
        rec_end = busy_until;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      // R1
      check(req_ready && !rd_valid, "R1", "ready/valid in reset", {req_ready, rd_valid}, 2'b10);
      check({mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe} == 5'b10110, "R1", "pins in reset",
            {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe}, 5'b10110);
    end else if (!done) begin
      bit rdy_m;
      logic [4:0] pins;
      rdy_m = (n >= busy_until) && !ret_m;
      pins  = {mem_sel_n, mem_sel, mem_we_n, mem_oe_n, mem_dq_oe};
      check(req_ready == rdy_m, ret_m ? "R7" : (n < rec_end ? "R8" : "R4"), "req_ready", req_ready, rdy_m);
      if (n == rv_edge) begin
        check(rd_valid, "R3", "rd_valid pulse", rd_valid, 1);
        check(rd_data == rv_exp, "R3", "rd_data", rd_data, rv_exp);
      end else check(!rd_valid, "R3", "rd_valid idle", rd_valid, 0);
      if (n >= w_lo && n <= w_hi) begin
        check(pins == 5'b01011, "R2", "write pins", pins, 5'b01011);
        check(mem_addr == w_addr && mem_dq_out == w_data, "R2", "write addr/data",
              {mem_addr, mem_dq_out}, {w_addr, w_data});
      end else if (n == w_hi + 1) begin
        check(pins == 5'b10111 && mem_dq_out == w_data, "R2", "write hold",
              {pins, mem_dq_out}, {5'b10111, w_data});
      end else if (n >= r_lo && n <= r_hi) begin
        check(pins == 5'b01100 && mem_addr == r_addr, "R3", "read pins",
              {pins, mem_addr}, {5'b01100, r_addr});
      end else if (rdy_m || ret_m) begin
        check(pins == 5'b10110, ret_m ? "R7" : "R6", "idle pins", pins, 5'b10110);
      end
    end
  end

  task automatic issue(bit w, logic [16:0] a, logic [7:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (acc_flag) break;
    end
    req_valid = 0;
  endtask

  task automatic drain();
    repeat (40) @(negedge clk);
  endtask

  initial begin
    #200000000;
  end

  initial begin : watchdog
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [16:0] lf;
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R2 R3 basic patterns and address corners
    issue(1, 17'h00000, 8'h3C);
    issue(1, 17'h1FFFF, 8'hC3);
    issue(1, 17'h0AAAA, 8'h5A);
    issue(0, 17'h00000, 8'h00);
    issue(0, 17'h1FFFF, 8'h00);
    // R5 write straight after a read waits out the turnaround
    issue(1, 17'h15555, 8'hA5);
    issue(0, 17'h15555, 8'h00);
    issue(0, 17'h0AAAA, 8'h00);
    drain();
    // R4 a request offered while busy is ignored
    issue(1, 17'h00123, 8'h11);
    req_valid = 1; req_write = 1; req_addr = 17'h00123; req_wdata = 8'hEE;
    repeat (2) @(negedge clk);
    req_valid = 0;
    drain();
    issue(0, 17'h00123, 8'h00);
    drain();
    // R7 R8 retention then recovery
    @(negedge clk); retain_req = 1;
    repeat (12) @(negedge clk);
    retain_req = 0;
    issue(1, 17'h00042, 8'h81);
    issue(0, 17'h00042, 8'h00);
    // mixed traffic
    lf = 17'h1ACE1;
    for (int i = 0; i < 24; i++) begin
      lf = {lf[15:0], lf[16] ^ lf[13]};
      issue(lf[0], {lf[16:4], 4'h0}, lf[12:5]);
    end
    drain();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule